// File: doc/BRIEF.md
# Splittable Auto-Reload Timer

This block is a 16-bit up-counter held in two byte registers. In the default mode the two bytes form one 16-bit counter. When it steps past 0xFFFF it takes a software-chosen 16-bit start value instead of returning to zero, and it raises a sticky high overflow flag. A mode bit turns the two bytes into two separate 8-bit counters, each with its own start value. In that mode the run bit gates only the high counter, and the low counter always counts.

The count rate comes from one of four places: every system clock, one pulse every 12 system clocks, one pulse per 8 rising edges of an external slow clock, or one pulse per rising edge of a comparator output. The two outside sources are brought into the system clock domain through a two-flop synchronizer and an edge detector. Software sets up the block and reads it back through a byte-wide register port. A single interrupt line reports the high overflow flag, and it can also report the low flag.

Top module: `split_reload_timer`

## Requirements
- R1: After reset every register reads 0x00 and irq is low. The register addresses are: 0 control, 1 flags, 2 counter low, 3 counter high, 4 reload low, 5 reload high. The control bits are: bit0 run, bit1 split, bit2 low-interrupt enable, bit3 interrupt enable, bit4 fast, bits6:5 source select. The flags bits are: bit0 low overflow, bit1 high overflow.
- R2: With split=0 and run=1, each count step adds one to the 16-bit value {high,low}. A step taken at 0xFFFF loads {reload high, reload low} and sets the high overflow flag.
- R3: With split=0, each step that takes the low byte past 0xFF sets the low overflow flag. This includes the step at 0xFFFF. The low byte wraps to 0x00 unless the whole 16-bit value wraps.
- R4: irq is high exactly when the interrupt enable bit is set and either the high flag is set, or both the low flag and the low-interrupt enable bit are set.
- R5: With split=1, each byte counts on its own. A step taken at 0xFF loads that byte's reload register and sets that byte's flag. The low byte counts whatever run is. The high byte counts only while run=1.
- R6: With fast=1, a count step occurs on every system clock, whatever the source select holds.
- R7: With fast=0 and select 00, a count step occurs once every 12 system clocks. Any 24 consecutive clocks give exactly 2 steps, and any 36 give exactly 3.
- R8: With fast=0 and select 01, a count step occurs on every 8th synchronized rising edge of the slow clock input.
- R9: With fast=0 and select 11, a count step occurs on each synchronized rising edge of the comparator input. Select 10 produces no steps.
- R10: The flags stay set until a write to the flags register. Writing a 0 to a flag bit clears that flag. Writing a 1 leaves it unchanged.
- R11: A write to a counter byte wins over a count step on that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_in | input | 1 | External slow clock, asynchronous |
| cmp_in | input | 1 | Comparator output, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The 16-bit path starts a few counts below 0xFFFF, so a single run crosses the reload. A start at 0x00FE exercises the carry into the high byte without a reload. Between them these show a reload apart from a plain wrap, and show which of the two flags each event sets. The split runs are made once with run clear and once with run set. That separates the free-running low byte from the gated high byte, and it shows that each byte reloads from its own register. The slow sources are checked over windows whose step count does not depend on the prescaler phase. A write made during counting shows whether the write or the increment lands in that cycle.

// File: rtl/split_reload_timer.sv
module split_reload_timer #(
  parameter int SYS_DIV  = 12,
  parameter int SLOW_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_in,
  input  logic       cmp_in,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int PW = $clog2(SYS_DIV);
  localparam int SW = $clog2(SLOW_DIV);

  logic [7:0] ctrl_q, cnt_lo, cnt_hi, rld_lo, rld_hi;
  logic [1:0] flags;
  logic [PW-1:0] pre;
  logic [SW-1:0] sdiv;
  logic [2:0] slow_s, cmp_s;
  logic tick;

  wire run   = ctrl_q[0];
  wire split = ctrl_q[1];
  wire lo_ie = ctrl_q[2];
  wire ie    = ctrl_q[3];
  wire fast  = ctrl_q[4];
  wire [1:0] sel = ctrl_q[6:5];

  wire pre_tick  = (pre == PW'(SYS_DIV - 1));
  wire slow_edge = slow_s[1] & ~slow_s[2];
  wire cmp_edge  = cmp_s[1] & ~cmp_s[2];
  wire slow_tick = slow_edge && (sdiv == SW'(SLOW_DIV - 1));

  always_comb begin
    case (sel)
      2'b00:   tick = pre_tick;
      2'b01:   tick = slow_tick;
      2'b11:   tick = cmp_edge;
      default: tick = 1'b0;
    endcase
    if (fast) tick = 1'b1;
  end

  wire lo_wrap = (cnt_lo == 8'hFF);
  wire hi_wrap = (cnt_hi == 8'hFF);
  wire lo_step = tick && (split || run);
  wire hi_step = tick && run && (split || lo_wrap);
  wire lo_set  = lo_step && lo_wrap;
  wire hi_set  = hi_step && hi_wrap;
  wire lo_load = lo_wrap && (split || hi_wrap);

  wire w_ctrl = wr_en && wr_addr == 3'd0;
  wire w_flag = wr_en && wr_addr == 3'd1;
  wire w_lo   = wr_en && wr_addr == 3'd2;
  wire w_hi   = wr_en && wr_addr == 3'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      sdiv   <= '0;
      slow_s <= '0;
      cmp_s  <= '0;
    end else begin
      slow_s <= {slow_s[1:0], slow_in};
      cmp_s  <= {cmp_s[1:0], cmp_in};
      pre    <= pre_tick ? '0 : pre + 1'b1;
      if (slow_edge) sdiv <= (sdiv == SW'(SLOW_DIV - 1)) ? '0 : sdiv + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_lo <= '0;
      rld_hi <= '0;
      cnt_lo <= '0;
      cnt_hi <= '0;
      flags  <= '0;
    end else begin
      if (w_ctrl) ctrl_q <= {1'b0, wr_data[6:0]};
      if (wr_en && wr_addr == 3'd4) rld_lo <= wr_data;
      if (wr_en && wr_addr == 3'd5) rld_hi <= wr_data;
      if (w_lo)         cnt_lo <= wr_data;
      else if (lo_step) cnt_lo <= lo_load ? rld_lo : cnt_lo + 8'd1;
      if (w_hi)         cnt_hi <= wr_data;
      else if (hi_step) cnt_hi <= hi_wrap ? rld_hi : cnt_hi + 8'd1;
      flags <= (flags & (w_flag ? wr_data[1:0] : 2'b11)) | {hi_set, lo_set};
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = ctrl_q;
      3'd1:    rd_data = {6'd0, flags};
      3'd2:    rd_data = cnt_lo;
      3'd3:    rd_data = cnt_hi;
      3'd4:    rd_data = rld_lo;
      3'd5:    rd_data = rld_hi;
      default: rd_data = 8'd0;
    endcase
  end

  assign irq = ie && (flags[1] || (lo_ie && flags[0]));
endmodule

module split_reload_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       irq,
  input logic [7:0] ctrl_q,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic [1:0] flags
);
  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !ctrl_q[1] && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
  p_hi_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(cnt_hi) == 8'hFF);
  p_lo_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(cnt_lo) == 8'hFF);
  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[3] || flags == 2'b00) |-> !irq);
  p_split_hi_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && !ctrl_q[0] && !(wr_en && wr_addr == 3'd3)) |=> $stable(cnt_hi));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !(wr_en && wr_addr == 3'd1)) |=> flags[1]);
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd2) |=> cnt_lo == $past(wr_data));
endmodule

bind split_reload_timer split_reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq(irq), .ctrl_q(ctrl_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .flags(flags)
);

// File: tb/split_reload_timer_test.sv
module split_reload_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, slow_in = 1'b0, cmp_in = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic irq;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  split_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .slow_in(slow_in), .cmp_in(cmp_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = it.is_irq ? {7'd0, irq} : rd_data;
        applied++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    rd_addr = a;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1 reset register");
    chk_irq(1'b0, "R1 reset irq");

    // R2/R3/R6: 16-bit reload across 0xFFFF
    wr(4, 8'h34); wr(5, 8'h12); wr(2, 8'hFD); wr(3, 8'hFF);
    wr(0, 8'h11); idle(4); wr(0, 8'h00);
    rd(2, 8'h36, "R2 low after reload");
    rd(3, 8'h12, "R2 high after reload");
    rd(1, 8'h03, "R3 both flags on full wrap");
    chk_irq(1'b0, "R4 irq off while disabled");
    wr(0, 8'h08);
    chk_irq(1'b1, "R4 irq on high flag");
    wr(1, 8'h02);
    rd(1, 8'h02, "R10 clear low only");
    chk_irq(1'b1, "R10 high flag still raises irq");
    wr(1, 8'h00);
    rd(1, 8'h00, "R10 clear all");
    chk_irq(1'b0, "R4 irq off after clear");

    // R3/R4: low-byte wrap in 16-bit mode
    wr(4, 8'h00); wr(5, 8'h00); wr(2, 8'hFE); wr(3, 8'h00);
    wr(0, 8'h1D); idle(2); wr(0, 8'h0C);
    rd(2, 8'h01, "R3 low byte after carry");
    rd(3, 8'h01, "R3 high byte after carry");
    rd(1, 8'h01, "R3 low flag only");
    chk_irq(1'b1, "R4 low interrupt enabled");
    wr(0, 8'h08);
    chk_irq(1'b0, "R4 low interrupt disabled");
    wr(1, 8'h00);

    // R5: split mode
    wr(4, 8'hF0); wr(5, 8'h80); wr(2, 8'hFE); wr(3, 8'hFE);
    wr(0, 8'h12); idle(3); wr(0, 8'h42);
    rd(2, 8'hF2, "R5 low runs without run bit");
    rd(3, 8'hFE, "R5 high held without run bit");
    rd(1, 8'h01, "R5 low flag in split");
    idle(10);
    rd(2, 8'hF2, "R9 select 10 gives no steps");
    wr(1, 8'h00);
    wr(0, 8'h13); idle(2); wr(0, 8'h42);
    rd(2, 8'hF5, "R5 low byte with run");
    rd(3, 8'h81, "R5 high reload from own register");
    rd(1, 8'h02, "R5 high flag in split");
    wr(1, 8'h00);

    // R11: write wins over count
    wr(2, 8'h20); wr(3, 8'h07);
    wr(0, 8'h11); wr(2, 8'h10); wr(0, 8'h00);
    rd(2, 8'h11, "R11 write beats increment");
    rd(3, 8'h07, "R11 high unchanged");

    // R7: divide by 12
    wr(2, 8'h00); wr(3, 8'h00);
    wr(0, 8'h01); idle(23); wr(0, 8'h00);
    rd(2, 8'h02, "R7 24 clocks give 2 steps");
    wr(2, 8'h00);
    wr(0, 8'h01); idle(35); wr(0, 8'h00);
    rd(2, 8'h03, "R7 36 clocks give 3 steps");

    // R8: slow clock divided by 8
    wr(2, 8'h00);
    wr(0, 8'h21);
    for (int i = 0; i < 16; i++) begin
      slow_in = 1'b1; idle(4);
      slow_in = 1'b0; idle(4);
    end
    idle(6); wr(0, 8'h00);
    rd(2, 8'h02, "R8 16 slow edges give 2 steps");

    // R9: comparator edges
    wr(2, 8'h00);
    wr(0, 8'h61);
    for (int i = 0; i < 5; i++) begin
      cmp_in = 1'b1; idle(3);
      cmp_in = 1'b0; idle(3);
    end
    idle(6); wr(0, 8'h00);
    rd(2, 8'h05, "R9 5 comparator edges");
    rd(3, 8'h00, "R9 high unchanged");

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule